// File: doc/BRIEF.md
# Matrix Keyboard Scanner with N-Key Lockout

This block walks a grid of 11 drive lines by 8 sense lines one key position per clock. It raises exactly one drive line at a time and looks at one sense input at a time. When the selected switch reads closed for a programmable number of consecutive clocks, the scan stops on that key. The data-available flag `da_n` is active low, and the frozen scan position is offered to the host as a key index.

The host clears `da_n` by asserting `rd_cs` for one clock. If the key is still held at that moment, the repeat flag `rpt_n` goes low and stays low while the key stays down. Software can use it for auto-repeat. Once the key has read open for a second programmable number of consecutive clocks, `rpt_n` returns high. The scan then resumes from the next position, but only after the host has also read the code. Any other key closed in the meantime is not seen until the scan reaches it, which gives N-key lockout.

Top module: `kbd_lockout_scanner`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block sets `key_idx` to 0, drives only `drive[0]` high, and sets both `da_n` and `rpt_n` high.
- R2: While no key is selected as closed, `key_idx` rises by one per clock and wraps from 87 to 0. `key_idx` equals drive line × 8 + sense line, and exactly one drive bit is high: bit `key_idx / 8`.
- R3: `da_n` falls at the clock edge where the selected key has read closed on `press_dly` consecutive edges. A `press_dly` of 0 acts as 1.
- R4: A closure of the selected key shorter than `press_dly` edges never lowers `da_n`. The scan moves on to the next index at the first edge that reads the key open.
- R5: While `da_n` is low and `rd_cs` is low, `key_idx` and `drive` stay constant.
- R6: A clock edge with `rd_cs` high and `da_n` low sets `da_n` high. `rd_cs` while `da_n` is already high changes nothing.
- R7: When a read clears `da_n` and the selected key reads closed at that edge, `rpt_n` falls at the same edge. It stays low while the key is held.
- R8: `rpt_n` returns high at the edge where the held key has read open on `rel_dly` consecutive edges (0 acts as 1). Any closed reading inside that window restarts the count.
- R9: The scan resumes at the next index at the later of two edges: the end of release debounce and the host read.
- R10: While one key is being reported, other closed keys are ignored. The next closed key in scan order is reported only after the first one is released and read.
- R11: After a read, `da_n` does not fall again while the same key stays held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| press_dly | input | 8 | Press debounce length in clocks |
| rel_dly | input | 8 | Release debounce length in clocks |
| sense | input | 8 | Sense lines, high where a closed switch meets the raised drive line |
| rd_cs | input | 1 | Host read strobe, sampled at the clock edge |
| drive | output | 11 | One-hot drive lines |
| key_idx | output | 7 | Current scan position, drive × 8 + sense |
| da_n | output | 1 | Data available, active low |
| rpt_n | output | 1 | Key still held after read, active low |

## Verification
A corrupted scan counter shows up on `drive` and `key_idx` at the very next clock. It also changes the edge at which `da_n` falls for a key placed at a known index. The scoreboard therefore predicts both the index and the exact edge count for every report. If the sequencing state were wrong, the flags would move at the wrong edge. Examples are a scan that resumes before the read, an `rpt_n` that rises early after a bounce, or a second report while the same key is held. To catch these, the bench samples `da_n`, `rpt_n` and `key_idx` one clock before and at the edge each requirement names.

// File: rtl/kscan_pkg.sv
// Shared types for the lockout keyboard scanner.
// Assumes nothing beyond a single clock domain.
package kscan_pkg;

    // Sequencing phases of the scanner controller.
    typedef enum logic [2:0] {
        PH_SCAN  = 3'd0,   // advancing one key position per clock
        PH_PRESS = 3'd1,   // candidate key found, counting closed edges
        PH_HELD  = 3'd2,   // key accepted and still closed
        PH_REL   = 3'd3,   // key opened, counting open edges
        PH_WAIT  = 3'd4    // key released and debounced, host has not read
    } kscan_phase_t;

endpackage

// File: rtl/kscan_position.sv
// Scan position counter: a sense counter (inner) and a drive counter (outer).
// Produces the one-hot drive lines, the key index and the selected sense bit.
// Assumes N_SENSE >= 2 and that sense is already synchronous to clk.
module kscan_position #(
    parameter int N_DRIVE = 11,
    parameter int N_SENSE = 8,
    parameter int RW      = (N_DRIVE > 1) ? $clog2(N_DRIVE) : 1,
    parameter int CW      = $clog2(N_SENSE),
    parameter int IW      = $clog2(N_DRIVE * N_SENSE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic [N_SENSE-1:0] sense,
    output logic [N_DRIVE-1:0] drive,
    output logic [IW-1:0]      key_idx,
    output logic               sel_closed
);

    localparam logic [RW-1:0] ROW_LAST = RW'(N_DRIVE - 1);
    localparam logic [CW-1:0] COL_LAST = CW'(N_SENSE - 1);

    logic [RW-1:0] row;
    logic [CW-1:0] col;

    // Advance the sense position, carrying into the drive position with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
            col <= '0;
        end else if (step) begin
            if (col == COL_LAST) begin
                col <= '0;
                row <= (row == ROW_LAST) ? '0 : row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    // Decode the drive position into one raised drive line per output.
    for (genvar g = 0; g < N_DRIVE; g++) begin : g_drv
        assign drive[g] = (row == RW'(g));
    end

    // Form the linear key index and pick the sense input being sampled.
    always_comb begin
        key_idx    = IW'(32'(row) * N_SENSE + 32'(col));
        sel_closed = sense[col];
    end

endmodule

// File: rtl/kscan_delay.sv
// Debounce delay counter: counts consecutive qualifying clocks.
// hit is high in the clock whose edge completes the programmed count.
// A limit of zero behaves as one. clr has priority over en.
module kscan_delay #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [DW-1:0] lim,
    output logic          hit
);

    localparam logic [DW-1:0] CNT_MAX = {DW{1'b1}};

    logic [DW-1:0] cnt;
    logic [DW-1:0] lim_eff;

    // Effective limit and completion test for the current clock.
    always_comb begin
        lim_eff = (lim == '0) ? DW'(1) : lim;
        hit     = en && (({1'b0, cnt} + 1'b1) >= {1'b0, lim_eff});
    end

    // Count qualifying clocks, saturating, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (en && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/kscan_ctrl.sv
// Scanner sequencing: decides when to step the scan, runs the two debounce
// counters, and owns the data-available and repeat flags.
// Assumes sel_closed reflects the key at the current scan position.
module kscan_ctrl
    import kscan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_cs,
    input  logic sel_closed,
    input  logic p_hit,
    input  logic r_hit,
    output logic step,
    output logic p_en,
    output logic p_clr,
    output logic r_en,
    output logic r_clr,
    output logic da_n,
    output logic rpt_n
);

    kscan_phase_t ph, ph_nx;
    logic         da_nx, rpt_nx;
    logic         rd_take;

    // Next phase, counter controls and flag updates for this clock.
    always_comb begin
        rd_take = rd_cs && !da_n;
        ph_nx   = ph;
        da_nx   = da_n;
        rpt_nx  = rpt_n;
        step    = 1'b0;
        p_en    = 1'b0;
        p_clr   = 1'b0;
        r_en    = 1'b0;
        r_clr   = 1'b0;
        case (ph)
            PH_SCAN: begin
                if (sel_closed) begin
                    p_en = 1'b1;
                    if (p_hit) begin
                        p_clr = 1'b1;
                        da_nx = 1'b0;
                        ph_nx = PH_HELD;
                    end else begin
                        ph_nx = PH_PRESS;
                    end
                end else begin
                    step = 1'b1;
                end
            end
            PH_PRESS: begin
                if (sel_closed) begin
                    p_en = 1'b1;
                    if (p_hit) begin
                        p_clr = 1'b1;
                        da_nx = 1'b0;
                        ph_nx = PH_HELD;
                    end
                end else begin
                    p_clr = 1'b1;
                    step  = 1'b1;
                    ph_nx = PH_SCAN;
                end
            end
            PH_HELD, PH_REL: begin
                if (rd_take) begin
                    da_nx = 1'b1;
                    if (sel_closed) begin
                        rpt_nx = 1'b0;
                    end
                end
                if (sel_closed) begin
                    r_clr = 1'b1;
                    ph_nx = PH_HELD;
                end else begin
                    r_en = 1'b1;
                    if (r_hit) begin
                        r_clr  = 1'b1;
                        rpt_nx = 1'b1;
                        if (da_nx) begin
                            step  = 1'b1;
                            ph_nx = PH_SCAN;
                        end else begin
                            ph_nx = PH_WAIT;
                        end
                    end else begin
                        ph_nx = PH_REL;
                    end
                end
            end
            PH_WAIT: begin
                if (rd_take) begin
                    da_nx = 1'b1;
                    step  = 1'b1;
                    ph_nx = PH_SCAN;
                end
            end
            default: begin
                ph_nx = PH_SCAN;
            end
        endcase
    end

    // Register phase and flags; reset leaves the scan running with flags idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph    <= PH_SCAN;
            da_n  <= 1'b1;
            rpt_n <= 1'b1;
        end else begin
            ph    <= ph_nx;
            da_n  <= da_nx;
            rpt_n <= rpt_nx;
        end
    end

endmodule

// File: rtl/kbd_lockout_scanner.sv
// Top level of the lockout keyboard scanner: position counter, two
// debounce counters (press and release) and the sequencing controller.
// Assumes sense and rd_cs are synchronous to clk.
module kbd_lockout_scanner #(
    parameter int N_DRIVE = 11,
    parameter int N_SENSE = 8,
    parameter int DLY_W   = 8,
    parameter int IW      = $clog2(N_DRIVE * N_SENSE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DLY_W-1:0]   press_dly,
    input  logic [DLY_W-1:0]   rel_dly,
    input  logic [N_SENSE-1:0] sense,
    input  logic               rd_cs,
    output logic [N_DRIVE-1:0] drive,
    output logic [IW-1:0]      key_idx,
    output logic               da_n,
    output logic               rpt_n
);

    logic step, sel_closed;
    logic p_en, p_clr, p_hit;
    logic r_en, r_clr, r_hit;

    kscan_position #(
        .N_DRIVE (N_DRIVE),
        .N_SENSE (N_SENSE),
        .IW      (IW)
    ) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .sense      (sense),
        .drive      (drive),
        .key_idx    (key_idx),
        .sel_closed (sel_closed)
    );

    kscan_delay #(.DW(DLY_W)) u_press (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (p_clr),
        .en    (p_en),
        .lim   (press_dly),
        .hit   (p_hit)
    );

    kscan_delay #(.DW(DLY_W)) u_rel (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (r_clr),
        .en    (r_en),
        .lim   (rel_dly),
        .hit   (r_hit)
    );

    kscan_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_cs      (rd_cs),
        .sel_closed (sel_closed),
        .p_hit      (p_hit),
        .r_hit      (r_hit),
        .step       (step),
        .p_en       (p_en),
        .p_clr      (p_clr),
        .r_en       (r_en),
        .r_clr      (r_clr),
        .da_n       (da_n),
        .rpt_n      (rpt_n)
    );

endmodule

// File: rtl/kscan_checker.sv
// Port-level properties of the lockout scanner, bound to the top module.
module kscan_checker #(
    parameter int N_DRIVE = 11,
    parameter int N_SENSE = 8,
    parameter int IW      = $clog2(N_DRIVE * N_SENSE)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_SENSE-1:0] sense,
    input logic               rd_cs,
    input logic [N_DRIVE-1:0] drive,
    input logic [IW-1:0]      key_idx,
    input logic               da_n,
    input logic               rpt_n
);

    localparam int CW = $clog2(N_SENSE);
    localparam int RW = (N_DRIVE > 1) ? $clog2(N_DRIVE) : 1;

    logic sel_seen;
    logic row_ok;

    // Sense bit and drive bit implied by the key index seen at the ports.
    always_comb begin
        sel_seen = sense[CW'(32'(key_idx) % N_SENSE)];
        row_ok   = drive[RW'(32'(key_idx) / N_SENSE)];
    end

    // R2: one drive line raised, matching the index, index in range
    a_r2_drive_matches: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(drive) == 1) && row_ok && (32'(key_idx) < N_DRIVE * N_SENSE));

    // R3: data available only falls after the selected key read closed
    a_r3_da_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(da_n) |-> $past(sel_seen));

    // R5: scan position frozen while a report is pending and not being read
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!da_n && !rd_cs) |=> $stable(key_idx));

    // R6: data available only clears through a read
    a_r6_clear_by_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(da_n) |-> $past(rd_cs));

    // R7: repeat only asserts on a read with the key still closed
    a_r7_rpt_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rpt_n) |-> ($past(rd_cs) && $past(sel_seen)));

    // R11: no new report while repeat is active
    a_r11_no_da_in_rpt: assert property (@(posedge clk) disable iff (!rst_n)
        !rpt_n |-> da_n);

endmodule

bind kbd_lockout_scanner kscan_checker #(
    .N_DRIVE (N_DRIVE),
    .N_SENSE (N_SENSE),
    .IW      (IW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sense   (sense),
    .rd_cs   (rd_cs),
    .drive   (drive),
    .key_idx (key_idx),
    .da_n    (da_n),
    .rpt_n   (rpt_n)
);

// File: tb/sim_kbd_lockout_scanner.sv
// Scoreboard bench: tests push expected reports (index, edge count) into a
// queue; a monitor pops one each time da_n falls and compares.
module sim_kbd_lockout_scanner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  press_dly = 8'd3;
    logic [7:0]  rel_dly = 8'd5;
    logic [7:0]  sense;
    logic        rd_cs = 1'b0;
    logic [10:0] drive;
    logic [6:0]  key_idx;
    logic        da_n, rpt_n;
    logic [87:0] keys = '0;

    int nchk = 0;
    int nfail = 0;
    int ecnt = 0;
    bit prev_da = 1'b1;
    bit finished = 1'b0;

    typedef struct { int idx; int cyc; } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    kbd_lockout_scanner u0 (
        .clk(clk), .rst_n(rst_n), .press_dly(press_dly), .rel_dly(rel_dly),
        .sense(sense), .rd_cs(rd_cs), .drive(drive), .key_idx(key_idx),
        .da_n(da_n), .rpt_n(rpt_n)
    );

    // Switch matrix model: a closed key ties its drive line to its sense line.
    always_comb begin
        for (int j = 0; j < 8; j++) begin
            sense[j] = 1'b0;
            for (int i = 0; i < 11; i++) begin
                if (drive[i] && keys[i*8+j]) sense[j] = 1'b1;
            end
        end
    end

    // Edge counter since reset release.
    always @(posedge clk) begin
        if (!rst_n) ecnt <= 0;
        else        ecnt <= ecnt + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: every falling da_n must match the head of the queue.
    always @(negedge clk) begin
        if (prev_da && !da_n) begin
            if (q.size() == 0) begin
                chk("R3/R11 unexpected report at edge", ecnt, -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk("R3 report index", int'(key_idx), e.idx);
                chk("R3 report edge", ecnt, e.cyc);
            end
        end
        prev_da = da_n;
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset(input logic [87:0] k);
        rst_n = 1'b0;
        rd_cs = 1'b0;
        keys  = k;
        tick(3);
        rst_n = 1'b1;
    endtask

    task automatic host_read();
        rd_cs = 1'b1;
        tick(1);
        rd_cs = 1'b0;
    endtask

    task automatic expect_report(input int idx, input int cyc);
        exp_t e;
        e.idx = idx;
        e.cyc = cyc;
        q.push_back(e);
    endtask

    function automatic logic [87:0] key_bit(input int k);
        logic [87:0] v;
        v = '0;
        v[k] = 1'b1;
        return v;
    endfunction

    initial begin
        int mark;
        @(negedge clk);
        // R1: reset state
        rst_n = 1'b0;
        tick(3);
        chk("R1 key_idx", int'(key_idx), 0);
        chk("R1 drive", int'(drive), 1);
        chk("R1 da_n", int'(da_n), 1);
        chk("R1 rpt_n", int'(rpt_n), 1);

        // R2: idle scanning, order, wrap; R6: read with da_n high ignored
        do_reset('0);
        tick(5);
        chk("R2 idx after 5", int'(key_idx), 5);
        chk("R2 drive row0", int'(drive), 1);
        tick(6);
        chk("R2 drive row1", int'(drive), 2);
        host_read();
        chk("R6 idle read idx", int'(key_idx), 12);
        chk("R6 idle read da_n", int'(da_n), 1);
        chk("R6 idle read rpt_n", int'(rpt_n), 1);
        tick(88 - 12 - 1);
        chk("R2 idx 87", int'(key_idx), 87);
        tick(1);
        chk("R2 wrap to 0", int'(key_idx), 0);

        // R3: press debounce timing at key 20, then R5/R9 release before read
        do_reset(key_bit(20));
        expect_report(20, 23);
        tick(22);
        chk("R3 not yet", int'(da_n), 1);
        tick(1);
        chk("R3 da_n low", int'(da_n), 0);
        chk("R2 drive row2", int'(drive), 4);
        tick(10);
        chk("R5 idx frozen", int'(key_idx), 20);
        keys = '0;
        tick(5);
        chk("R8 rpt_n stays high w/o read", int'(rpt_n), 1);
        tick(5);
        chk("R9 waits for read idx", int'(key_idx), 20);
        chk("R9 waits for read da_n", int'(da_n), 0);
        host_read();
        chk("R6 read clears da_n", int'(da_n), 1);
        chk("R9 resumes on read", int'(key_idx), 21);

        // R4: glitch of 2 edges at key 30 (press_dly 3)
        do_reset(key_bit(30));
        tick(32);
        keys = '0;
        tick(1);
        chk("R4 scan moves on", int'(key_idx), 31);
        tick(100);
        chk("R4 no report", int'(da_n), 1);

        // R10/R7/R11/R8: keys 40 and 50 both closed
        do_reset(key_bit(40) | key_bit(50));
        expect_report(40, 43);
        tick(43);
        host_read();
        chk("R6 da_n cleared", int'(da_n), 1);
        chk("R7 rpt_n low", int'(rpt_n), 0);
        tick(20);
        chk("R11 no re-report", int'(da_n), 1);
        chk("R7 rpt_n held", int'(rpt_n), 0);
        chk("R10 idx locked", int'(key_idx), 40);
        keys[40] = 1'b0;
        tick(4);
        chk("R8 rpt_n before window", int'(rpt_n), 0);
        tick(1);
        chk("R8 rpt_n released", int'(rpt_n), 1);
        chk("R9 resume after release", int'(key_idx), 41);
        mark = ecnt;
        expect_report(50, mark + 12);
        tick(12);
        chk("R10 second key idx", int'(key_idx), 50);
        chk("R10 second key da_n", int'(da_n), 0);

        // R8: bounce during release restarts the window, key 70
        do_reset(key_bit(70));
        expect_report(70, 73);
        tick(73);
        host_read();
        keys = '0;
        tick(3);
        keys = key_bit(70);
        tick(1);
        chk("R8 bounce keeps rpt_n", int'(rpt_n), 0);
        keys = '0;
        tick(4);
        chk("R8 restarted window", int'(rpt_n), 0);
        tick(1);
        chk("R8 window done", int'(rpt_n), 1);
        chk("R9 resume after bounce", int'(key_idx), 71);

        // R3: press_dly of 0 acts as 1, key 5
        press_dly = 8'd0;
        do_reset(key_bit(5));
        expect_report(5, 6);
        tick(6);
        chk("R3 zero load da_n", int'(da_n), 0);
        chk("R3 zero load idx", int'(key_idx), 5);
        press_dly = 8'd3;

        tick(2);
        chk("R3 queue drained", q.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // Watchdog: a hung run ends as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule